// File: doc/BRIEF.md
# Converter Core Power Sequencer

This block brings the digital core of a data converter up from power-down and takes it back down. It filters the external active-low power pin and then closes the core supply switch. The switch closes at once when the core is fed from outside. When the on-chip regulator feeds the core, the switch waits for an oscillator count first. Once the sample clocks are present, the block starts the clock divider after a fixed number of frames and then drives the outputs. In pin-control mode the core leaves reset together with the divider. In register-control mode the core waits for a software run bit. That bit releases the reset and reasserts it with different frame latencies.

A regulator overvoltage or overcurrent fault trips a lockout while the regulator strap is set. The lockout shuts the core off and floats the outputs. Only a full power-pin low/high cycle clears it. Losing the clocks drops the block back to waiting for clocks and keeps the run-bit setting. All inputs are synchronous to `clk`. The ticks are one-cycle strobes. The straps are static while the power pin is high.

Top module: `core_pwr_seq`

## Requirements
- R1: While the filtered power pin is low, and out of `rst_n`, the outputs `pwr_released`, `sw_on`, `div_on`, `core_rst_n`, `drive_en` and `fault_latched` are all 0.
- R2: A change of `pwr_n` takes effect only after it has been held through GLITCH_TICKS consecutive `osc_tick` strobes. A shorter low pulse changes no output.
- R3: With `vreg_strap` = 1, `sw_on` rises on the SWITCH_TICKS-th `osc_tick` after `pwr_released` rises.
- R4: With `vreg_strap` = 0, `sw_on` rises exactly one clock after `pwr_released`.
- R5: With `sw_on` high, `div_on` and `drive_en` stay 0 until `clk_present` is 1. They rise on the DIV_FRAMES-th `frame_tick` counted from the first clock that sees `clk_present`.
- R6: With `regctl_strap` = 0 (pin control), `core_rst_n` rises in the same cycle as `div_on`.
- R7: With `regctl_strap` = 1 (register control), `core_rst_n` stays 0 after `div_on` rises. It rises on the RUN_FRAMES-th `frame_tick` after `soft_run` goes to 1.
- R8: In register control, `soft_run` held at 0 lowers `core_rst_n` on the HALT_FRAMES-th `frame_tick`, while `div_on` and `drive_en` stay 1. A 0 pulse shorter than that has no effect.
- R9: With `vreg_strap` = 1, `vreg_ov` or `vreg_oc` while `pwr_released` is high sets `fault_latched` and clears `pwr_released`, `sw_on`, `div_on` and `drive_en` at the next clock. The lockout holds until the filtered power pin goes low. Faults are ignored when `vreg_strap` = 0.
- R10: Dropping `clk_present` while `div_on` is high clears `div_on`, `drive_en` and `core_rst_n` at the next clock and keeps `sw_on`. When the clocks return, the run-bit state held before the loss applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| pwr_n | input | 1 | External power-down pin, low = power down |
| vreg_strap | input | 1 | 1 = core fed by on-chip regulator |
| regctl_strap | input | 1 | 1 = register-control mode, 0 = pin-control mode |
| soft_run | input | 1 | Software run bit (1 = core out of reset) |
| clk_present | input | 1 | All required sample clocks detected |
| osc_tick | input | 1 | One-cycle strobe from the free-running oscillator |
| frame_tick | input | 1 | One-cycle strobe once per frame |
| vreg_ov | input | 1 | Regulator overvoltage flag |
| vreg_oc | input | 1 | Regulator overcurrent flag |
| pwr_released | output | 1 | Internal power-down release |
| sw_on | output | 1 | Core supply switch enable |
| div_on | output | 1 | Clock divider enable |
| core_rst_n | output | 1 | Digital core reset, active low |
| drive_en | output | 1 | 1 = outputs driven, 0 = high impedance |
| fault_latched | output | 1 | Regulator fault lockout status |

## Verification
The assertions check several rules on every clock. They check that a low filtered pin empties every output one clock later. They check that the filter and run-bit gate flip only on a tick toward their input. They also check the one-clock switch closure without the regulator, the fault trip and its hold, and the drop of the divider on clock loss. Only the bench scenarios show the tick counts. These are the filter length, the regulator switch delay, the divider frame delay, and the unequal release and assert latencies of the run bit. The bench also shows that short pin or run-bit pulses are ignored and that the run state survives a clock loss.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SWITCH  = 3'd1,
    ST_CLKWAIT = 3'd2,
    ST_DIVWAIT = 3'd3,
    ST_UP      = 3'd4,
    ST_FAULT   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/tick_debounce.sv
// Level filter: output follows input only after the mismatch has lasted
// a set number of tick strobes; separate counts for each direction.
module tick_debounce #(
  parameter int unsigned RISE_TICKS = 3,
  parameter int unsigned FALL_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int unsigned MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  assign target = dout ? CW'(FALL_TICKS) : CW'(RISE_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == target - CW'(1)) begin
        dout <= din;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2 (power pin), R7/R8 (run bit): a flip only on a tick, toward the input
  p_flip_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout != $past(dout)) && !$past(clr)) |-> ($past(tick) && ($past(din) == dout)));
endmodule

// File: rtl/tick_timer.sv
// Counts tick strobes while enabled; done pulses on the N-th one.
module tick_timer #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= cnt + CW'(1);
  end

  assign done = run && tick && (cnt == CW'(N - 1));
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int unsigned GLITCH_TICKS = 4,
  parameter int unsigned SWITCH_TICKS = 64,
  parameter int unsigned DIV_FRAMES   = 4,
  parameter int unsigned RUN_FRAMES   = 2,
  parameter int unsigned HALT_FRAMES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_n,
  input  logic vreg_strap,
  input  logic regctl_strap,
  input  logic soft_run,
  input  logic clk_present,
  input  logic osc_tick,
  input  logic frame_tick,
  input  logic vreg_ov,
  input  logic vreg_oc,
  output logic pwr_released,
  output logic sw_on,
  output logic div_on,
  output logic core_rst_n,
  output logic drive_en,
  output logic fault_latched
);
  seq_state_e state, nxt;
  logic pwr_ok, soft_ok, sw_done, div_done, fault_hit;

  tick_debounce #(.RISE_TICKS(GLITCH_TICKS), .FALL_TICKS(GLITCH_TICKS)) u_pin_filter (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .tick(osc_tick), .din(pwr_n), .dout(pwr_ok));

  // Run bit: release after RUN_FRAMES frames, halt after HALT_FRAMES frames.
  tick_debounce #(.RISE_TICKS(RUN_FRAMES), .FALL_TICKS(HALT_FRAMES)) u_run_gate (
    .clk(clk), .rst_n(rst_n), .clr(!pwr_ok), .tick(frame_tick), .din(soft_run), .dout(soft_ok));

  tick_timer #(.N(SWITCH_TICKS)) u_switch_timer (
    .clk(clk), .rst_n(rst_n), .run((state == ST_SWITCH) && vreg_strap),
    .tick(osc_tick), .done(sw_done));

  tick_timer #(.N(DIV_FRAMES)) u_div_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_DIVWAIT),
    .tick(frame_tick), .done(div_done));

  assign fault_hit = vreg_strap && (vreg_ov || vreg_oc) &&
                     (state != ST_OFF) && (state != ST_FAULT);

  always_comb begin
    nxt = state;
    if (!pwr_ok)        nxt = ST_OFF;
    else if (fault_hit) nxt = ST_FAULT;
    else begin
      unique case (state)
        ST_OFF:     nxt = ST_SWITCH;
        ST_SWITCH:  if (!vreg_strap || sw_done) nxt = ST_CLKWAIT;
        ST_CLKWAIT: if (clk_present) nxt = ST_DIVWAIT;
        ST_DIVWAIT: begin
          if (!clk_present)  nxt = ST_CLKWAIT;
          else if (div_done) nxt = ST_UP;
        end
        ST_UP:      if (!clk_present) nxt = ST_CLKWAIT;
        ST_FAULT:   nxt = ST_FAULT;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign pwr_released  = (state != ST_OFF) && (state != ST_FAULT);
  assign sw_on         = (state == ST_CLKWAIT) || (state == ST_DIVWAIT) || (state == ST_UP);
  assign div_on        = (state == ST_UP);
  assign drive_en      = (state == ST_UP);
  assign core_rst_n    = (state == ST_UP) && (!regctl_strap || soft_ok);
  assign fault_latched = (state == ST_FAULT);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!pwr_released && !sw_on && !div_on && !drive_en && !core_rst_n && !fault_latched));

  p_sw_prompt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_released) && !vreg_strap && pwr_ok) |=> sw_on);

  p_pin_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div_on) && !regctl_strap) |-> core_rst_n);

  p_fault_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && pwr_released && vreg_strap && (vreg_ov || vreg_oc)) |=>
      (fault_latched && !drive_en && !sw_on && !pwr_released));

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && pwr_ok) |=> fault_latched);

  p_clk_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_on && !clk_present && pwr_ok) |=> (!div_on && !drive_en && !core_rst_n));
endmodule

// File: tb/test_core_pwr_seq.sv
`timescale 1ns/1ps
module test_core_pwr_seq;
  localparam int GL = 3, SW = 5, DIV = 4, RUNF = 2, HALT = 3;
  localparam int OSC_DIV = 4, FR_DIV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_n = 0, vreg_strap = 0, regctl_strap = 0, soft_run = 0, clk_present = 0;
  logic osc_tick = 0, frame_tick = 0, vreg_ov = 0, vreg_oc = 0;
  logic pwr_released, sw_on, div_on, core_rst_n, drive_en, fault_latched;

  int checks = 0, fails = 0, cyc = 0, n_osc = 0, n_frm = 0;
  bit done = 0;

  core_pwr_seq #(.GLITCH_TICKS(GL), .SWITCH_TICKS(SW), .DIV_FRAMES(DIV),
                 .RUN_FRAMES(RUNF), .HALT_FRAMES(HALT)) i_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .vreg_strap(vreg_strap),
    .regctl_strap(regctl_strap), .soft_run(soft_run), .clk_present(clk_present),
    .osc_tick(osc_tick), .frame_tick(frame_tick), .vreg_ov(vreg_ov), .vreg_oc(vreg_oc),
    .pwr_released(pwr_released), .sw_on(sw_on), .div_on(div_on), .core_rst_n(core_rst_n),
    .drive_en(drive_en), .fault_latched(fault_latched));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc        <= cyc + 1;
    osc_tick   <= ((cyc % OSC_DIV) == 0);
    frame_tick <= ((cyc % FR_DIV) == 0);
  end

  always @(posedge clk) begin
    if (osc_tick)   n_osc <= n_osc + 1;
    if (frame_tick) n_frm <= n_frm + 1;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_osc(int n);
    int t0 = n_osc;
    while (n_osc - t0 < n) step();
  endtask

  // Leave the next edge free of a frame strobe.
  task automatic align_frame();
    while (!frame_tick) step();
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic check_quiet(string req);
    chk(req, {pwr_released, sw_on, div_on, core_rst_n, drive_en, fault_latched}, 0);
  endtask

  task automatic run_config(bit vr, bit rc);
    int t0;
    vreg_strap = vr; regctl_strap = rc;
    pwr_n = 0; clk_present = 0; soft_run = 0; vreg_ov = 0; vreg_oc = 0;
    wait_osc(GL + 2); step();
    check_quiet("R1 power low");

    // R2: release after GL oscillator ticks
    t0 = n_osc; pwr_n = 1;
    for (int i = 0; i < 500 && !pwr_released; i++) step();
    chk("R2 release ticks", n_osc - t0, GL);

    t0 = n_osc;
    if (vr) begin
      for (int i = 0; i < 500 && !sw_on; i++) step();
      chk("R3 switch ticks", n_osc - t0, SW);
    end else begin
      chk("R4 switch before edge", sw_on, 0);
      step();
      chk("R4 switch one clock later", sw_on, 1);
    end
    repeat (20) step();
    chk("R5 no clocks keeps float", {div_on, drive_en}, 0);

    align_frame();
    t0 = n_frm; clk_present = 1;
    for (int i = 0; i < 500 && !div_on; i++) step();
    chk("R5 divider frames", n_frm - t0, DIV);
    chk("R5 drive with divider", drive_en, 1);
    chk(rc ? "R7 core held in reset" : "R6 pin core release", core_rst_n, !rc);

    if (rc) begin
      repeat (40) step();
      chk("R7 still held without run bit", core_rst_n, 0);
      t0 = n_frm; soft_run = 1;
      for (int i = 0; i < 500 && !core_rst_n; i++) step();
      chk("R7 release frames", n_frm - t0, RUNF);
      // R8: short halt pulse ignored
      t0 = n_frm; soft_run = 0;
      while (n_frm - t0 < HALT - 1) step();
      soft_run = 1;
      repeat (20) step();
      chk("R8 short halt ignored", core_rst_n, 1);
      t0 = n_frm; soft_run = 0;
      for (int i = 0; i < 500 && core_rst_n; i++) step();
      chk("R8 halt frames", n_frm - t0, HALT);
      chk("R8 outputs stay driven", {div_on, drive_en}, 3);
      soft_run = 1;
      for (int i = 0; i < 500 && !core_rst_n; i++) step();
    end

    // R10: clock loss and return
    clk_present = 0; step();
    chk("R10 clock loss drops", {div_on, drive_en, core_rst_n}, 0);
    chk("R10 switch kept", sw_on, 1);
    align_frame();
    clk_present = 1;
    for (int i = 0; i < 500 && !div_on; i++) step();
    chk("R10 run state kept", core_rst_n, 1);

    // R2: sweep of short low pulses
    for (int k = 1; k < GL; k++) begin
      t0 = n_osc; pwr_n = 0;
      while (n_osc - t0 < k) step();
      pwr_n = 1;
      repeat (20) step();
      chk($sformatf("R2 glitch of %0d ticks ignored", k), {pwr_released, drive_en}, 3);
    end

    // R9: faults
    if (vr) begin
      vreg_ov = 1; step(); vreg_ov = 0;
      chk("R9 trip", {fault_latched, pwr_released, sw_on, drive_en}, 4'b1000);
      repeat (30) step();
      chk("R9 lockout held", fault_latched, 1);
    end else begin
      vreg_oc = 1; repeat (10) step(); vreg_oc = 0;
      chk("R9 fault ignored without regulator", {fault_latched, drive_en}, 2'b01);
    end

    pwr_n = 0;
    wait_osc(GL); step();
    check_quiet("R1 R9 power cycle clears");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) step();
    check_quiet("R1 reset state");
    rst_n = 1;
    step();
    check_quiet("R1 after reset");
    for (int v = 0; v < 2; v++)
      for (int r = 0; r < 2; r++)
        run_config(v[0], r[0]);
    finish_run();
  end
endmodule